// File: doc/BRIEF.md
# Transition-Signalled Wrapper for a Locally Clocked Core

This block sits between a network of self-timed links and a synchronous processing core. Each network link uses two-phase signalling. A change of level on a request line, in either direction, announces a new data word. A change of level on the matching acknowledge line closes that transfer. The wrapper takes one word from the input link, hands it to the core, and enables the core only until the core reports completion. It then offers the result on the output link and holds it there until the far side acknowledges it.

The incoming request and acknowledge lines are treated as asynchronous. Each one passes through a two-stage synchronizer before any edge is detected. The wrapper handles one item at a time. While an output result is still waiting for its acknowledge, a pending input request is left waiting. The sender therefore sees back-pressure, because its acknowledge does not arrive.

Top module: `tphase_wrap`

## Requirements
- R1: After reset, in_ack_o, out_req_o and core_en_o are 0, and the wrapper is idle.
- R2: A level change on in_req_i, in either direction, is accepted when the wrapper is idle. On acceptance in_data_i is captured and driven on core_data_o. in_ack_o then toggles on the clock edge after the capture edge.
- R3: in_req_i passes through two synchronizer flops. If in_req_i changes between two clock edges while the wrapper is idle, in_ack_o changes right after the fourth rising edge that follows.
- R4: core_en_o goes high on the edge where in_ack_o toggles. It stays high up to and including the edge where core_done_i is sampled high, and is low at all other times. A core that raises done after N extra enabled cycles therefore receives N+1 enabled edges.
- R5: core_done_i has no effect while core_en_o is low. Neither out_req_o nor out_data_o changes.
- R6: out_data_o takes core_data_i on the edge where done is sampled. out_req_o toggles on the next edge.
- R7: From an out_req_o toggle until the matching out_ack_i toggle is seen, out_data_o holds its value.
- R8: While an output transfer is unacknowledged, no input is accepted: in_ack_o and core_en_o stay still. A waiting input request is accepted once the out_ack_i toggle is seen. This toggle is synchronized by two flops, so in_ack_o changes right after the fifth edge that follows the out_ack_i change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_data_i | input | DW | Input link data, stable before in_req_i changes |
| in_req_i | input | 1 | Input link request phase (asynchronous) |
| in_ack_o | output | 1 | Input link acknowledge phase |
| out_data_o | output | DW | Output link data |
| out_req_o | output | 1 | Output link request phase |
| out_ack_i | input | 1 | Output link acknowledge phase (asynchronous) |
| core_data_o | output | DW | Operand presented to the core |
| core_en_o | output | 1 | Clock enable for the core |
| core_data_i | input | DW | Result from the core |
| core_done_i | input | 1 | Core completion flag |

## Verification
The bench drives requests as falling as well as rising transitions. A design that detects only rising edges would stall on every second word. It measures the exact number of edges from a request change to the acknowledge. A missing or extra synchronizer stage, or an acknowledge sent before capture, shows up as a wrong count. A result is held back without acknowledge while a new request arrives. A wrapper without back-pressure would acknowledge the new word and overwrite out_data_o. The bench also pulses done while the core is disabled; a wrapper that ignores the enable would emit a bogus result. Latency zero and long latency at the core check that the enable window is exactly one edge longer than the core latency.

// File: rtl/tphase_pkg.sv
package tphase_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACK,
    ST_RUN,
    ST_SEND
  } wrap_st_e;
endpackage

// File: rtl/tp_sync.sv
module tp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/tp_phase_track.sv
// Keeps the last consumed phase; evt_o flags an unconsumed transition.
module tp_phase_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phase_i,
  input  logic take_i,
  output logic evt_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_q <= 1'b0;
    else if (take_i) seen_q <= phase_i;
  end

  assign evt_o = phase_i ^ seen_q;
endmodule

// File: rtl/tp_ctrl.sv
module tp_ctrl
  import tphase_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_evt_i,
  input  logic          ack_evt_i,
  input  logic [DW-1:0] in_data_i,
  input  logic [DW-1:0] core_data_i,
  input  logic          core_done_i,
  output logic          req_take_o,
  output logic          in_ack_o,
  output logic          out_req_o,
  output logic [DW-1:0] out_data_o,
  output logic [DW-1:0] core_data_o,
  output logic          core_en_o
);
  wrap_st_e      st_q;
  logic          pend_q;
  logic          ack_q, req_q;
  logic [DW-1:0] op_q, res_q;
  logic          accept;

  assign accept     = (st_q == ST_IDLE) && req_evt_i && !pend_q;
  assign req_take_o = accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
      req_q <= 1'b0;
      op_q  <= '0;
      res_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          op_q <= in_data_i;
          st_q <= ST_ACK;
        end
        ST_ACK: begin
          ack_q <= ~ack_q;
          st_q  <= ST_RUN;
        end
        ST_RUN: if (core_done_i) begin
          res_q <= core_data_i;
          st_q  <= ST_SEND;
        end
        ST_SEND: begin
          req_q <= ~req_q;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // output transfer outstanding until the synchronized ack transition
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pend_q <= 1'b0;
    else if (st_q == ST_SEND)  pend_q <= 1'b1;
    else if (ack_evt_i)        pend_q <= 1'b0;
  end

  assign in_ack_o    = ack_q;
  assign out_req_o   = req_q;
  assign out_data_o  = res_q;
  assign core_data_o = op_q;
  assign core_en_o   = (st_q == ST_RUN);
endmodule

// File: rtl/tphase_wrap.sv
module tphase_wrap #(
  parameter int DW      = 8,
  parameter int SYNC_FF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_req_i,
  output logic          in_ack_o,
  output logic [DW-1:0] out_data_o,
  output logic          out_req_o,
  input  logic          out_ack_i,
  output logic [DW-1:0] core_data_o,
  output logic          core_en_o,
  input  logic [DW-1:0] core_data_i,
  input  logic          core_done_i
);
  logic req_s, ack_s;
  logic req_evt, ack_evt, req_take;

  tp_sync #(.STAGES(SYNC_FF)) u_req_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(in_req_i), .q_o(req_s));

  tp_sync #(.STAGES(SYNC_FF)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(out_ack_i), .q_o(ack_s));

  tp_phase_track u_req_trk (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_i(req_s), .take_i(req_take), .evt_o(req_evt));

  // ack phase always absorbed; a stray toggle with nothing pending is dropped
  tp_phase_track u_ack_trk (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_i(ack_s), .take_i(1'b1), .evt_o(ack_evt));

  tp_ctrl #(.DW(DW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_evt_i  (req_evt),
    .ack_evt_i  (ack_evt),
    .in_data_i  (in_data_i),
    .core_data_i(core_data_i),
    .core_done_i(core_done_i),
    .req_take_o (req_take),
    .in_ack_o   (in_ack_o),
    .out_req_o  (out_req_o),
    .out_data_o (out_data_o),
    .core_data_o(core_data_o),
    .core_en_o  (core_en_o)
  );
endmodule

// File: rtl/tphase_wrap_chk.sv
module tphase_wrap_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_ack_o,
  input logic          out_req_o,
  input logic          out_ack_i,
  input logic [DW-1:0] out_data_o,
  input logic [DW-1:0] core_data_o,
  input logic          core_en_o,
  input logic          core_done_i
);
  // R4: an input acknowledge coincides with the start of the enable window
  p_en_on_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(in_ack_o) |-> core_en_o);

  // R2: operand already captured and unchanged when acknowledge moves
  p_op_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(in_ack_o) |-> $stable(core_data_o));

  // R5 / R6: an output request only follows an enabled done two samples back
  p_req_after_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_req_o) |-> $past(core_done_i && core_en_o, 2));

  // R7: result held while the output link is unacknowledged
  p_out_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_req_o != out_ack_i) |=> $stable(out_data_o));

  // R8: no input acknowledge while output is outstanding
  p_backpressure_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_req_o != out_ack_i) |=> $stable(in_ack_o));
endmodule

bind tphase_wrap tphase_wrap_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_ack_o   (in_ack_o),
  .out_req_o  (out_req_o),
  .out_ack_i  (out_ack_i),
  .out_data_o (out_data_o),
  .core_data_o(core_data_o),
  .core_en_o  (core_en_o),
  .core_done_i(core_done_i)
);

// File: tb/tphase_wrap_tb_top.sv
module tphase_wrap_tb_top;
  localparam int DW = 8;
  localparam int NV = 5;
  // {operand[19:12], core latency[11:8], expected result[7:0]}; core returns ~operand
  localparam logic [19:0] VEC [NV] = '{
    20'h3C2C3, 20'h000FF, 20'hA555A, 20'hFF100, 20'h8137E
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_req = 1'b0, out_ack = 1'b0;
  logic in_ack, out_req, core_en, core_done;
  logic [DW-1:0] out_data, core_op, core_res;

  int total = 0, bad = 0;
  int cyc = 0, done_cyc = 0, en_cnt = 0;
  logic [3:0] lat_q = '0, cnt = '0;
  logic spur_done = 1'b0;

  always #5 clk = ~clk;

  tphase_wrap #(.DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_data_i(in_data), .in_req_i(in_req), .in_ack_o(in_ack),
    .out_data_o(out_data), .out_req_o(out_req), .out_ack_i(out_ack),
    .core_data_o(core_op), .core_en_o(core_en),
    .core_data_i(core_res), .core_done_i(core_done)
  );

  // behavioural core: done after lat_q extra enabled cycles, result = ~operand
  assign core_done = (core_en && cnt == lat_q) || spur_done;
  assign core_res  = spur_done ? 8'h55 : ~core_op;

  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) cnt <= '0;
    else if (core_en) begin
      en_cnt <= en_cnt + 1;
      if (core_done) begin
        cnt      <= '0;
        done_cyc <= cyc + 1;
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ack_chg(output int n);
    logic old = in_ack;
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); n++;
      if (in_ack != old) return;
    end
    n = -1;
  endtask

  task automatic wait_req_chg(output int n);
    logic old = out_req;
    n = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk); n++;
      if (out_req != old) return;
    end
    n = -1;
  endtask

  task automatic xfer(input logic [7:0] d, input logic [3:0] lat,
                      input logic [7:0] exp, input bit do_ack);
    int n, e0;
    @(negedge clk);
    lat_q   = lat;
    in_data = d;
    in_req  = ~in_req;
    wait_ack_chg(n);
    chk(n == 4, "R3 req-to-ack edges", n, 4);
    chk(core_op == d, "R2 operand capture", core_op, d);
    chk(core_en == 1'b1, "R4 enable with ack", core_en, 1);
    e0 = en_cnt;
    wait_req_chg(n);
    chk(n > 0, "R6 output request seen", n, 1);
    chk(out_data == exp, "R6 result data", out_data, exp);
    chk(cyc == done_cyc + 1, "R6 req one edge after done", cyc - done_cyc, 1);
    chk(en_cnt - e0 == int'(lat) + 1, "R4 enabled edges", en_cnt - e0, int'(lat) + 1);
    chk(core_en == 1'b0, "R4 enable dropped", core_en, 0);
    if (do_ack) begin
      out_ack = ~out_ack;
      repeat (5) @(negedge clk);
    end
  endtask

  initial begin
    int n;
    logic [7:0] held;
    logic a0, r0;
    repeat (3) @(negedge clk);
    chk(in_ack == 0 && out_req == 0 && core_en == 0, "R1 reset state",
        {in_ack, out_req, core_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(in_ack == 0 && core_en == 0, "R1 idle after reset", {in_ack, core_en}, 0);

    // table walk: requests alternate rising and falling transitions
    for (int v = 0; v < NV; v++)
      xfer(VEC[v][19:12], VEC[v][11:8], VEC[v][7:0], 1'b1);

    // R8 / R7: hold result unacknowledged, offer a new word
    xfer(8'h5A, 4'd1, 8'hA5, 1'b0);
    held = out_data;
    a0   = in_ack;
    in_data = 8'h12;
    lat_q   = 4'd2;
    in_req  = ~in_req;
    repeat (12) @(negedge clk);
    chk(in_ack == a0, "R8 no ack while output pending", in_ack, a0);
    chk(core_en == 1'b0, "R8 core idle while pending", core_en, 0);
    chk(out_data == held, "R7 result held", out_data, held);
    out_ack = ~out_ack;
    wait_ack_chg(n);
    chk(n == 5, "R8 accept after out ack", n, 5);
    chk(core_op == 8'h12, "R8 waiting word captured", core_op, 8'h12);
    wait_req_chg(n);
    chk(out_data == 8'hED, "R8 waiting word result", out_data, 8'hED);
    out_ack = ~out_ack;
    repeat (5) @(negedge clk);

    // R5: done pulse with core disabled
    held = out_data;
    r0   = out_req;
    spur_done = 1'b1;
    repeat (3) @(negedge clk);
    spur_done = 1'b0;
    repeat (4) @(negedge clk);
    chk(out_req == r0, "R5 stray done no request", out_req, r0);
    chk(out_data == held, "R5 stray done no data", out_data, held);

    // latency 0 after stray done: still exact
    xfer(8'hC0, 4'd0, 8'h3F, 1'b1);

    // R1: reset in the middle of a computation
    @(negedge clk);
    lat_q   = 4'd9;
    in_data = 8'h77;
    in_req  = ~in_req;
    repeat (7) @(negedge clk);
    rst_n   = 1'b0;
    in_req  = 1'b0;
    out_ack = 1'b0;
    @(negedge clk);
    chk(in_ack == 0 && out_req == 0 && core_en == 0, "R1 mid-run reset",
        {in_ack, out_req, core_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    xfer(8'h0F, 4'd2, 8'hF0, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule